// File: doc/BRIEF.md
# Single-Bit Boolean Unit

This unit executes one-bit boolean commands for an 8-bit microcontroller core. Each command carries an operation code and an 8-bit bit number. The unit turns the bit number into a byte address and a bit position. The byte is either one of the sixteen bit-addressable internal RAM bytes or one of the special-function bytes whose address is a multiple of eight. A single carry flag, held in the unit and shown on `carry_o`, works as a one-bit accumulator.

Commands that need the target bit read the byte through a synchronous byte port. Commands that change the target bit write the byte back one cycle after the read, with only that one bit altered. Commands that act on the carry alone, and unknown codes, finish in one cycle and never touch the port. A busy/done pair tells the issuing logic when the next command may be sent.

Top module: `bitop_unit`

## Requirements
- R1: While `rst_ni` is low, `carry_o`, `busy_o`, `done_o`, `mem_re_o` and `mem_we_o` are all 0.
- R2: A bit number N below 80h addresses byte 20h + N/8 at bit position N mod 8 (for example, 1Ah gives byte 23h, bit 2).
- R3: A bit number N of 80h or above addresses the byte N with its low three bits cleared, at bit position N mod 8. Only bytes ending in 0h or 8h are ever reached.
- R4: A command is accepted on a clock edge where `cmd_valid_i` is high and `busy_o` is low. For byte commands, `mem_re_o` is high in the next cycle. In the cycle after that, `done_o` is high, together with `mem_we_o` when a write is needed. `busy_o` stays high from acceptance through the done cycle. The carry takes its new value at the end of the done cycle.
- R5: A write puts the byte just read back at the same address, with every bit except the target unchanged.
- R6: Codes 5, 6 and 7 clear, set and complement the target bit. The carry is unchanged.
- R7: Code 1 copies the carry into the target bit.
- R8: Code 0 copies the target bit into the carry and performs no write.
- R9: Codes 8, 9, 10 and 11 set the carry to C AND bit, C AND NOT bit, C OR bit and C OR NOT bit. They perform no write.
- R10: Codes 2, 3 and 4 clear, set and complement the carry. They raise `done_o` in the cycle right after acceptance and neither read nor write.
- R11: `cmd_valid_i` is ignored while `busy_o` is high.
- R12: Codes 12 to 15 behave like the carry-only commands in timing, and change neither the carry nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 4 | Operation code |
| cmd_bit_i | input | 8 | Bit number |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Last cycle of a command |
| carry_o | output | 1 | Carry flag |
| mem_re_o | output | 1 | Byte read strobe |
| mem_we_o | output | 1 | Byte write strobe |
| mem_addr_o | output | 8 | Byte address |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Byte read, valid the cycle after `mem_re_o` |

## Verification
The bench builds the unit with its default parameters: 8-bit bytes and bit numbers, the RAM window at 20h, and the split between RAM and special-function bytes at 80h. These values reach both ends of the RAM window (bits 00h and 7Fh) and special-function bytes at the bottom (80h), in the middle (D0h) and at the top (F8h). A bench-side memory starts with a distinct value in every byte, so any stray write to a byte that is not bit-addressable, or to a neighbouring bit, shows up in the final full-image comparison.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [3:0] {
    OP_C_FROM_BIT = 4'd0,
    OP_BIT_FROM_C = 4'd1,
    OP_C_CLR      = 4'd2,
    OP_C_SET      = 4'd3,
    OP_C_CPL      = 4'd4,
    OP_B_CLR      = 4'd5,
    OP_B_SET      = 4'd6,
    OP_B_CPL      = 4'd7,
    OP_C_AND      = 4'd8,
    OP_C_AND_N    = 4'd9,
    OP_C_OR       = 4'd10,
    OP_C_OR_N     = 4'd11
  } bitop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EXEC = 2'd2
  } bitop_state_e;

  function automatic logic op_needs_byte(bitop_e op);
    case (op)
      OP_C_FROM_BIT, OP_BIT_FROM_C,
      OP_B_CLR, OP_B_SET, OP_B_CPL,
      OP_C_AND, OP_C_AND_N, OP_C_OR, OP_C_OR_N: return 1'b1;
      default:                                  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode #(
  parameter int BIT_ADDR_W = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 3,
  parameter int RAM_BASE   = 'h20,
  parameter int SFR_SPLIT  = 'h80
) (
  input  logic [BIT_ADDR_W-1:0] bit_addr_i,
  output logic [ADDR_W-1:0]     byte_addr_o,
  output logic [IDX_W-1:0]      bit_idx_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(DATA_W - 1);

  always_comb begin
    bit_idx_o = bit_addr_i[IDX_W-1:0];
    if (int'(bit_addr_i) < SFR_SPLIT)
      byte_addr_o = ADDR_W'(RAM_BASE) + ADDR_W'(bit_addr_i >> IDX_W);
    else
      byte_addr_o = ADDR_W'(bit_addr_i) & ~LOW_MASK;
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  bitop_e             op_i,
  input  logic [DATA_W-1:0]  rdata_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               carry_i,
  output logic               carry_o,
  output logic               we_o,
  output logic [DATA_W-1:0]  wdata_o
);
  logic bit_v, new_bit;

  always_comb begin
    bit_v   = rdata_i[idx_i];
    carry_o = carry_i;
    we_o    = 1'b0;
    new_bit = bit_v;
    case (op_i)
      OP_C_FROM_BIT: carry_o = bit_v;
      OP_BIT_FROM_C: begin we_o = 1'b1; new_bit = carry_i; end
      OP_C_CLR:      carry_o = 1'b0;
      OP_C_SET:      carry_o = 1'b1;
      OP_C_CPL:      carry_o = ~carry_i;
      OP_B_CLR:      begin we_o = 1'b1; new_bit = 1'b0; end
      OP_B_SET:      begin we_o = 1'b1; new_bit = 1'b1; end
      OP_B_CPL:      begin we_o = 1'b1; new_bit = ~bit_v; end
      OP_C_AND:      carry_o = carry_i & bit_v;
      OP_C_AND_N:    carry_o = carry_i & ~bit_v;
      OP_C_OR:       carry_o = carry_i | bit_v;
      OP_C_OR_N:     carry_o = carry_i | ~bit_v;
      default:       ;
    endcase
    wdata_o        = rdata_i;
    wdata_o[idx_i] = new_bit;
  end
endmodule

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  bitop_e            cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  output bitop_e            op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              read_o,
  output logic              exec_o,
  output logic              busy_o
);
  bitop_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_o    <= OP_C_FROM_BIT;
      addr_o  <= '0;
      idx_o   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          op_o    <= cmd_op_i;
          addr_o  <= cmd_addr_i;
          idx_o   <= cmd_idx_i;
          state_q <= op_needs_byte(cmd_op_i) ? ST_READ : ST_EXEC;
        end
        ST_READ: state_q <= ST_EXEC;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign read_o = (state_q == ST_READ);
  assign exec_o = (state_q == ST_EXEC);
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int BIT_ADDR_W = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int RAM_BASE   = 'h20,
  parameter int SFR_SPLIT  = 'h80
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [3:0]            cmd_op_i,
  input  logic [BIT_ADDR_W-1:0] cmd_bit_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  carry_o,
  output logic                  mem_re_o,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  input  logic [DATA_W-1:0]     mem_rdata_i
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] dec_addr;
  logic [IDX_W-1:0]  dec_idx, idx_q;
  bitop_e            op_q;
  logic              exec, alu_carry, alu_we, carry_q;

  bitop_decode #(
    .BIT_ADDR_W(BIT_ADDR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .RAM_BASE(RAM_BASE), .SFR_SPLIT(SFR_SPLIT)
  ) u_decode (
    .bit_addr_i (cmd_bit_i),
    .byte_addr_o(dec_addr),
    .bit_idx_o  (dec_idx)
  );

  bitop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (bitop_e'(cmd_op_i)),
    .cmd_addr_i (dec_addr),
    .cmd_idx_i  (dec_idx),
    .op_o       (op_q),
    .addr_o     (mem_addr_o),
    .idx_o      (idx_q),
    .read_o     (mem_re_o),
    .exec_o     (exec),
    .busy_o     (busy_o)
  );

  bitop_alu #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_alu (
    .op_i   (op_q),
    .rdata_i(mem_rdata_i),
    .idx_i  (idx_q),
    .carry_i(carry_q),
    .carry_o(alu_carry),
    .we_o   (alu_we),
    .wdata_o(mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   carry_q <= 1'b0;
    else if (exec) carry_q <= alu_carry;
  end

  assign mem_we_o = exec & alu_we;
  assign done_o   = exec;
  assign carry_o  = carry_q;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 3,
  parameter int RAM_BASE  = 'h20,
  parameter int SFR_SPLIT = 'h80
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [3:0]        cmd_op_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              carry_o,
  input logic              mem_re_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] mem_rdata_i
);
  localparam int RAM_END = RAM_BASE + SFR_SPLIT / DATA_W;

  always_ff @(posedge clk_i)
    if (!rst_ni)
      assert_reset_quiet_R1: assert (!busy_o && !done_o && !carry_o && !mem_re_o && !mem_we_o);

  assert_bit_region_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o || mem_we_o) |->
      ((int'(mem_addr_o) >= RAM_BASE && int'(mem_addr_o) < RAM_END) ||
       (int'(mem_addr_o) >= SFR_SPLIT && mem_addr_o[IDX_W-1:0] == '0)));

  assert_write_after_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o));

  assert_read_then_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> done_o);

  assert_done_releases_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  assert_carry_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(carry_o));

  assert_same_byte_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $stable(mem_addr_o));

  assert_one_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($countones(mem_wdata_o ^ mem_rdata_i) <= 1));

  assert_carry_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_op_i >= 4'd2 && cmd_op_i <= 4'd4) |=>
      (done_o && !mem_re_o && !mem_we_o));
endmodule

bind bitop_unit bitop_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
  .RAM_BASE(RAM_BASE), .SFR_SPLIT(SFR_SPLIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .carry_o    (carry_o),
  .mem_re_o   (mem_re_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_rdata_i(mem_rdata_i)
);

// File: tb/bitop_unit_tb.sv
`timescale 1ns/1ps
module bitop_unit_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       cmd_valid_i;
  logic [3:0] cmd_op_i;
  logic [7:0] cmd_bit_i;
  logic       busy_o, done_o, carry_o, mem_re_o, mem_we_o;
  logic [7:0] mem_addr_o, mem_wdata_o;
  logic [7:0] mem_rdata_i;

  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];
  logic       ref_c;
  int checks = 0;
  int errors = 0;
  bit summary_done = 0;

  always #2 clk_i = ~clk_i;

  bitop_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
    .cmd_op_i(cmd_op_i), .cmd_bit_i(cmd_bit_i), .busy_o(busy_o),
    .done_o(done_o), .carry_o(carry_o), .mem_re_o(mem_re_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  always @(posedge clk_i) begin
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  function automatic logic [7:0] byte_of(int n);
    if (n < 128) return 8'(32 + n / 8);
    return 8'(n - n % 8);
  endfunction

  task automatic run(input int op, input int n, input string req, input bit junk);
    logic [7:0] ea = byte_of(n);
    int idx = n % 8;
    bit mem_op = (op <= 11) && !(op inside {2, 3, 4});
    logic b = ref_mem[ea][idx];
    logic exp_c = ref_c;
    bit exp_we = 0;
    logic nb = b;
    logic [7:0] exp_w;
    case (op)
      0: exp_c = b;
      1: begin exp_we = 1; nb = ref_c; end
      2: exp_c = 0;
      3: exp_c = 1;
      4: exp_c = !ref_c;
      5: begin exp_we = 1; nb = 0; end
      6: begin exp_we = 1; nb = 1; end
      7: begin exp_we = 1; nb = !b; end
      8: exp_c = ref_c & b;
      9: exp_c = ref_c & !b;
      10: exp_c = ref_c | b;
      11: exp_c = ref_c | !b;
      default: ;
    endcase
    exp_w = ref_mem[ea];
    exp_w[idx] = nb;

    @(negedge clk_i);
    cmd_valid_i = 1; cmd_op_i = 4'(op); cmd_bit_i = 8'(n);
    @(negedge clk_i);
    if (junk) cmd_op_i = 4'd4; else cmd_valid_i = 0;
    if (mem_op) begin
      chk(busy_o && mem_re_o && !mem_we_o && !done_o, "R4", "read cycle strobes",
          {busy_o, mem_re_o, mem_we_o, done_o}, 4'b1100);
      chk(mem_addr_o == ea, req, "byte address", mem_addr_o, ea);
      @(negedge clk_i);
    end
    chk(done_o && busy_o && !mem_re_o, "R4", "done cycle strobes",
        {done_o, busy_o, mem_re_o}, 3'b110);
    chk(mem_we_o == exp_we, req, "write strobe", mem_we_o, exp_we);
    if (exp_we) begin
      chk(mem_wdata_o == exp_w, "R5", "write data", mem_wdata_o, exp_w);
      chk(mem_addr_o == ea, req, "write address", mem_addr_o, ea);
      ref_mem[ea] = exp_w;
    end
    ref_c = exp_c;
    @(negedge clk_i);
    cmd_valid_i = 0;
    chk(!busy_o && !done_o && !mem_we_o && !mem_re_o, "R4", "idle after done",
        {busy_o, done_o, mem_we_o, mem_re_o}, 0);
    chk(carry_o == ref_c, req, "carry", carry_o, ref_c);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'((i * 37 + 5) % 256);
      ref_mem[i] = mem[i];
    end
    ref_c = 0;
    rst_ni = 0; cmd_valid_i = 0; cmd_op_i = 0; cmd_bit_i = 0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !carry_o && !mem_re_o && !mem_we_o, "R1", "reset outputs",
        {busy_o, done_o, carry_o, mem_re_o, mem_we_o}, 0);
    rst_ni = 1;

    run(3, 'h00, "R10", 0);
    run(1, 'h1A, "R7", 0);
    run(2, 'h00, "R10", 0);
    run(0, 'h1A, "R8", 0);
    run(0, 'h7F, "R2", 0);
    run(6, 'h00, "R6", 0);
    run(5, 'h07, "R6", 0);
    run(7, 'h87, "R3", 0);
    run(7, 'hD7, "R3", 0);
    run(6, 'hFD, "R3", 0);
    run(3, 'h00, "R10", 0);
    run(8, 'h40, "R9", 0);
    run(9, 'h41, "R9", 0);
    run(10, 'h42, "R9", 0);
    run(11, 'h43, "R9", 0);
    run(4, 'h00, "R10", 0);
    run(13, 'h22, "R12", 0);
    run(15, 'h90, "R12", 0);
    run(1, 'h55, "R11", 1);
    run(5, 'hA3, "R11", 1);
    run(4, 'h00, "R11", 1);
    for (int i = 0; i < 48; i++)
      run(i % 16, (i * 53 + 11) % 256, "R5", 0);

    begin
      int mm = 0;
      int first = -1;
      for (int i = 0; i < 256; i++)
        if (mem[i] !== ref_mem[i]) begin
          mm++;
          if (first < 0) first = i;
        end
      chk(mm == 0, "R9", "memory image mismatches", mm, 0);
    end
    summary();
    $finish;
  end
endmodule